// File: doc/BRIEF.md
# Folded Quarter-Wave Sine Lookup with Coarse/Fine Correction

This block turns a phase word into a signed sine amplitude for a direct digital synthesizer. Only the upper phase bits are used. The two top bits pick the quadrant. The bit below the top one mirrors the read of a stored quarter wave. The top bit negates the result. The remaining in-quadrant index is split into a coarse angle and a fine angle. The coarse angle reads a main table of the quarter-wave sine. A second table, much narrower and addressed by the upper coarse bits together with the fine bits, supplies the small term cos(coarse)·sin(fine). This applies the angle-sum identity with cos(fine) taken as one.

Phase words arrive on a valid/ready input stream, and samples leave on a valid/ready output stream. The datapath is a three-stage pipeline: fold, table read, then add and negate. All stages advance together whenever the output register is empty or being drained. A transfer happens on a rising clock edge when valid and ready are both high. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While a sample waits with `out_ready` low, `out_sample` is held unchanged and no new phase is accepted. Samples leave in the order their phases were accepted, one per accepted phase.

Top module: `sine_fold_lut`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: With `out_ready` held high, a phase accepted on one edge gives `out_valid` high after the third rising edge counted from and including the accepting edge. Under this condition a new phase is accepted on every edge.
- R3: While `out_valid` is high and `out_ready` is low, `in_ready` is low. On the next edge `out_valid` stays high and `out_sample` keeps its value.
- R4: Every accepted phase produces exactly one sample, in acceptance order. This holds under any pattern of `in_valid` and `out_ready`. A phase always yields the same sample value.
- R5: For every phase code p of the PHASE_W-bit input, `out_sample` is within 2 LSB of round(AMP·sin(2π(p+0.5)/2^PHASE_W)), where AMP = 2^(OUT_W-1)-3.
- R6: Bit PHASE_W-1 of the phase negates the sample, and bit PHASE_W-2 mirrors the quarter. With Q = 2^(PHASE_W-2) and 0 ≤ q < Q, sample(Q+q) = sample(Q-1-q), sample(2Q+q) = -sample(q), and sample(3Q+q) = -sample(Q-1-q), all exactly.
- R7: |out_sample| never exceeds AMP+2, so no wrap occurs at the peaks. The samples at codes Q-1 and Q are at least AMP-2.
- R8: When `in_valid` stays low, no sample is produced: once the pipeline has drained, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Phase word present |
| in_ready | output | 1 | Block can accept a phase word this edge |
| in_phase | input | PHASE_W | Upper bits of the phase accumulator |
| out_valid | output | 1 | Sample present |
| out_ready | input | 1 | Consumer takes the sample this edge |
| out_sample | output | OUT_W | Signed two's complement sine sample |

## Verification
The hardest case to reach from the ports is the one where the pipeline is full and stalled. Bubbles are then stuck in the middle stages, and the consumer releases back-pressure at the same edge on which the producer offers a new phase. Only that case shows whether data is dropped or doubled. The bench first sweeps every phase code with the output always ready, which fills a table of reference samples. It then runs a long stretch with random `in_valid` and `out_ready` and phases biased toward the quadrant edges. That run produces many stall/release collisions, and each output is matched against the sweep table in order.

// File: rtl/sine_fold_pkg.sv
package sine_fold_pkg;

  // pi/2 scaled by 2^30
  localparam longint HALFPI_Q30 = 64'sd1686629713;
  localparam longint ONE_Q30    = 64'sd1 <<< 30;

  // angle in radians (Q30) for an index counted in half steps of a quarter
  // that has 2^qw steps
  function automatic longint half_to_rad(input longint h, input int qw);
    return (h * HALFPI_Q30) >>> (qw + 1);
  endfunction

  // Taylor series, adequate on [0, pi/2]
  function automatic longint sin_q30(input longint x);
    longint x2, term, acc;
    x2   = (x * x) >>> 30;
    term = x;
    acc  = x;
    for (int k = 1; k <= 7; k++) begin
      term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic longint cos_q30(input longint x);
    longint x2, term, acc;
    x2   = (x * x) >>> 30;
    term = ONE_Q30;
    acc  = ONE_Q30;
    for (int k = 1; k <= 7; k++) begin
      term = -((term * x2) >>> 30) / longint'((2 * k - 1) * (2 * k));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic int scale_amp(input longint s, input int amp);
    return int'((s * longint'(amp) + (64'sd1 <<< 29)) >>> 30);
  endfunction

  // coarse table: sin of the coarse angle alone
  function automatic int coarse_entry(input int i, input int qw, input int bw,
                                      input int amp);
    longint h;
    h = longint'(2 * i) * (64'sd1 <<< bw);
    return scale_amp(sin_q30(half_to_rad(h, qw)), amp);
  endfunction

  // fine table: cos(centre of coarse group) * sin(fine angle incl. half step)
  function automatic int fine_entry(input int i, input int qw, input int aw,
                                    input int ahw, input int bw, input int amp);
    longint ha, hb, grp, stp, prod;
    int g, b;
    g    = i >> bw;
    b    = i & ((1 << bw) - 1);
    grp  = 64'sd1 <<< (aw - ahw);
    stp  = 64'sd1 <<< bw;
    ha   = 2 * longint'(g) * grp * stp + (grp - 1) * stp;
    hb   = 2 * longint'(b) + 1;
    prod = (cos_q30(half_to_rad(ha, qw)) * sin_q30(half_to_rad(hb, qw))) >>> 30;
    return scale_amp(prod, amp);
  endfunction

endpackage

// File: rtl/sine_rom.sv
module sine_rom #(
  parameter int KIND   = 0,   // 0: coarse sine table, 1: fine correction table
  parameter int QW     = 10,
  parameter int A_W    = 7,
  parameter int AH_W   = 5,
  parameter int B_W    = 3,
  parameter int AMP    = 2045,
  parameter int DATA_W = 11,
  localparam int ADDR_W = (KIND == 0) ? A_W : (AH_W + B_W),
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  import sine_fold_pkg::*;

  logic [DATA_W-1:0] tbl [DEPTH];

  generate
    if (KIND == 0) begin : g_coarse
      for (genvar i = 0; i < DEPTH; i++) begin : g_e
        assign tbl[i] = DATA_W'(coarse_entry(i, QW, B_W, AMP));
      end
    end else begin : g_fine
      for (genvar i = 0; i < DEPTH; i++) begin : g_e
        assign tbl[i] = DATA_W'(fine_entry(i, QW, A_W, AH_W, B_W, AMP));
      end
    end
  endgenerate

  assign data = tbl[addr];
endmodule

// File: rtl/sine_fold_stage.sv
module sine_fold_stage #(
  parameter int PHASE_W = 12,
  parameter int A_W     = 7,
  localparam int QW     = PHASE_W - 2,
  localparam int B_W    = QW - A_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               v_in,
  input  logic [PHASE_W-1:0] phase,
  output logic               v_q,
  output logic               neg_q,
  output logic [A_W-1:0]     a_q,
  output logic [B_W-1:0]     b_q
);
  logic [QW-1:0] idx;

  // mirrored quadrant reads the quarter backwards
  assign idx = phase[PHASE_W-2] ? ~phase[QW-1:0] : phase[QW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      neg_q <= 1'b0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (en) begin
      v_q   <= v_in;
      neg_q <= phase[PHASE_W-1];
      a_q   <= idx[QW-1 -: A_W];
      b_q   <= idx[B_W-1:0];
    end
  end
endmodule

// File: rtl/sine_lookup_stage.sv
module sine_lookup_stage #(
  parameter int QW     = 10,
  parameter int A_W    = 7,
  parameter int AH_W   = 5,
  parameter int AMP    = 2045,
  parameter int MAIN_W = 11,
  parameter int CORR_W = 5,
  localparam int B_W   = QW - A_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              v_in,
  input  logic              neg_in,
  input  logic [A_W-1:0]    a_in,
  input  logic [B_W-1:0]    b_in,
  output logic              v_q,
  output logic              neg_q,
  output logic [MAIN_W-1:0] main_q,
  output logic [CORR_W-1:0] corr_q
);
  logic [MAIN_W-1:0] main_d;
  logic [CORR_W-1:0] corr_d;

  sine_rom #(.KIND(0), .QW(QW), .A_W(A_W), .AH_W(AH_W), .B_W(B_W),
             .AMP(AMP), .DATA_W(MAIN_W)) u_coarse (
    .addr(a_in),
    .data(main_d)
  );

  sine_rom #(.KIND(1), .QW(QW), .A_W(A_W), .AH_W(AH_W), .B_W(B_W),
             .AMP(AMP), .DATA_W(CORR_W)) u_fine (
    .addr({a_in[A_W-1 -: AH_W], b_in}),
    .data(corr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      neg_q  <= 1'b0;
      main_q <= '0;
      corr_q <= '0;
    end else if (en) begin
      v_q    <= v_in;
      neg_q  <= neg_in;
      main_q <= main_d;
      corr_q <= corr_d;
    end
  end
endmodule

// File: rtl/sine_sum_stage.sv
module sine_sum_stage #(
  parameter int OUT_W  = 12,
  parameter int CORR_W = 5,
  localparam int MAIN_W = OUT_W - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    v_in,
  input  logic                    neg_in,
  input  logic [MAIN_W-1:0]       main_in,
  input  logic [CORR_W-1:0]       corr_in,
  output logic                    v_q,
  output logic signed [OUT_W-1:0] sample_q
);
  logic signed [OUT_W-1:0] mag;

  assign mag = signed'({1'b0, main_in}) +
               signed'({{(OUT_W-CORR_W){1'b0}}, corr_in});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q      <= 1'b0;
      sample_q <= '0;
    end else if (en) begin
      v_q      <= v_in;
      sample_q <= neg_in ? -mag : mag;
    end
  end
endmodule

// File: rtl/sine_fold_lut.sv
module sine_fold_lut #(
  parameter int PHASE_W = 12,
  parameter int OUT_W   = 12,
  parameter int A_W     = 7,
  parameter int AH_W    = 5,
  parameter int CORR_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [PHASE_W-1:0]      in_phase,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_sample
);
  localparam int QW     = PHASE_W - 2;
  localparam int B_W    = QW - A_W;
  localparam int MAIN_W = OUT_W - 1;
  localparam int AMP    = (1 << (OUT_W - 1)) - 3;

  logic              en;
  logic              v1, n1, v2, n2;
  logic [A_W-1:0]    a1;
  logic [B_W-1:0]    b1;
  logic [MAIN_W-1:0] m2;
  logic [CORR_W-1:0] c2;

  // whole pipeline moves when the output slot is free or being emptied
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  sine_fold_stage #(.PHASE_W(PHASE_W), .A_W(A_W)) u_fold (
    .clk(clk), .rst_n(rst_n), .en(en), .v_in(in_valid), .phase(in_phase),
    .v_q(v1), .neg_q(n1), .a_q(a1), .b_q(b1)
  );

  sine_lookup_stage #(.QW(QW), .A_W(A_W), .AH_W(AH_W), .AMP(AMP),
                      .MAIN_W(MAIN_W), .CORR_W(CORR_W)) u_look (
    .clk(clk), .rst_n(rst_n), .en(en), .v_in(v1), .neg_in(n1),
    .a_in(a1), .b_in(b1),
    .v_q(v2), .neg_q(n2), .main_q(m2), .corr_q(c2)
  );

  sine_sum_stage #(.OUT_W(OUT_W), .CORR_W(CORR_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .en(en), .v_in(v2), .neg_in(n2),
    .main_in(m2), .corr_in(c2),
    .v_q(out_valid), .sample_q(out_sample)
  );
endmodule

// File: rtl/sine_fold_lut_chk.sv
module sine_fold_lut_chk #(
  parameter int OUT_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_sample
);
  localparam int LIM = (1 << (OUT_W - 1)) - 1;  // AMP + 2

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R3: stalled sample is held
  assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

  // R3: no intake while stalled
  assert_no_intake_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R2: three-edge latency when the pipe keeps moving
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(in_valid && in_ready, 3) &&
     $past(in_ready, 2) && $past(in_ready, 1)) |-> out_valid);

  // R7: no wrap at the peaks
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sample <= LIM && out_sample >= -LIM));
endmodule

bind sine_fold_lut sine_fold_lut_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
);

// File: tb/test_sine_fold_lut.sv
`timescale 1ns/1ps
module test_sine_fold_lut;
  localparam int PHASE_W = 12;
  localparam int OUT_W   = 12;
  localparam int N       = 1 << PHASE_W;
  localparam int Q       = N / 4;
  localparam int AMP     = (1 << (OUT_W - 1)) - 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [PHASE_W-1:0] in_phase = '0;
  logic signed [OUT_W-1:0] out_sample;

  int tests = 0, fails = 0;
  int res [N];
  int exp_q [$];
  bit sweep_mode = 1'b1;
  bit held = 1'b0;
  int held_val = 0;
  int accepts = 0;

  always #2.5 clk = ~clk;

  sine_fold_lut #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) i_sine_fold_lut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample)
  );

  function automatic int ref_sample(input int p);
    real x;
    x = 2.0 * 3.14159265358979323846 * (real'(p) + 0.5) / real'(N);
    return int'(real'(AMP) * $sin(x));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input int p, input logic rdy);
    int ph, d;
    @(negedge clk);
    in_valid  = v;
    in_phase  = PHASE_W'(p);
    out_ready = rdy;
    #0.5;
    if (held) begin
      chk(out_valid == 1'b1, "R3 valid held", int'(out_valid), 1);
      chk(int'(out_sample) == held_val, "R3 sample held", int'(out_sample), held_val);
    end
    held = out_valid && !out_ready;
    held_val = int'(out_sample);
    if (held) chk(in_ready == 1'b0, "R3 in_ready low", int'(in_ready), 0);
    if (in_valid && in_ready) begin
      exp_q.push_back(p);
      accepts++;
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected sample", int'(out_sample), 0);
      end else begin
        ph = exp_q.pop_front();
        if (sweep_mode) begin
          res[ph] = int'(out_sample);
          d = res[ph] - ref_sample(ph);
          chk(d <= 2 && d >= -2, "R5 accuracy", res[ph], ref_sample(ph));
        end else begin
          chk(int'(out_sample) == res[ph], "R4 order/value", int'(out_sample), res[ph]);
        end
      end
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    int corner [8];
    int lat, mx, mn, r;
    corner = '{0, Q-1, Q, 2*Q-1, 2*Q, 3*Q-1, 3*Q, N-1};
    r = $urandom(32'h5eed_1234);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // full sweep, consumer always ready (R5, R2 throughput)
    for (int p = 0; p < N; p++) begin
      step(1'b1, p, 1'b1);
    end
    chk(accepts == N, "R2 one phase per edge", accepts, N);
    repeat (5) step(1'b0, 0, 1'b1);
    chk(exp_q.size() == 0, "R4 sweep drained", exp_q.size(), 0);

    // exact symmetries (R6) and peak bounds (R7)
    for (int q = 0; q < Q; q++) begin
      chk(res[Q+q] == res[Q-1-q], "R6 mirrored quarter", res[Q+q], res[Q-1-q]);
      chk(res[2*Q+q] == -res[q], "R6 negated half", res[2*Q+q], -res[q]);
      chk(res[3*Q+q] == -res[Q-1-q], "R6 negated mirror", res[3*Q+q], -res[Q-1-q]);
    end
    mx = res[0]; mn = res[0];
    for (int p = 1; p < N; p++) begin
      if (res[p] > mx) mx = res[p];
      if (res[p] < mn) mn = res[p];
    end
    chk(mx <= AMP + 2, "R7 positive peak bound", mx, AMP + 2);
    chk(mn >= -(AMP + 2), "R7 negative peak bound", mn, -(AMP + 2));
    chk(res[Q-1] >= AMP - 2, "R7 peak at Q-1", res[Q-1], AMP - 2);
    chk(res[Q] >= AMP - 2, "R7 peak at Q", res[Q], AMP - 2);

    // latency of a single phase into an empty pipe (R2)
    @(negedge clk);
    in_valid = 1'b1; in_phase = PHASE_W'(Q); out_ready = 1'b1;
    lat = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      #0.5;
      if (out_valid && lat == 0) begin
        lat = k;
        chk(int'(out_sample) == res[Q], "R2 single sample value", int'(out_sample), res[Q]);
      end
    end
    chk(lat == 3, "R2 latency", lat, 3);
    held = 1'b0;

    // random valid/ready with corner phases (R3, R4)
    sweep_mode = 1'b0;
    for (int i = 0; i < 8000; i++) begin
      int p;
      if ($urandom % 6 == 0) p = corner[$urandom % 8];
      else p = int'($urandom % N);
      step(($urandom % 4) != 0, p, ($urandom % 3) != 0);
    end
    repeat (8) step(1'b0, 0, 1'b1);
    chk(exp_q.size() == 0, "R4 no lost sample", exp_q.size(), 0);

    // idle input produces nothing (R8)
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 0, 1'b1);
      chk(out_valid == 1'b0, "R8 idle no output", int'(out_valid), 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule